// File: doc/BRIEF.md
# Small-Divisor Reciprocal Divider

This block divides an unsigned dividend by an unsigned divisor and returns the floor quotient and the remainder. It sends each request down one of four routes, based on the divisor alone:

- **Zero divisor.** The request finishes at once with a division-by-zero flag.
- **Exact power of two, including 1.** The quotient is a right shift and the remainder is a mask, so the answer is ready in one cycle.
- **Small divisor that is not a power of two.** The block reads a reciprocal from an on-chip table and multiplies the dividend by it in a pipelined multiplier. It rounds the upper product bits to estimate the quotient. A remainder step and a one-step correction then make the result exact.
- **Any other divisor.** A restoring divider produces one quotient bit per clock.

A request is a single-cycle `start_i` pulse that is sampled while `ready_o` is high. The result appears on a one-cycle `done_o` pulse. A path code comes with the result and tells the caller which route produced it, so the latency depends on the data. Outputs are registered and hold their values until the next result.

Top module: `recip_divider`

## Requirements
- R1: A divisor of 0 raises `done_o` in the cycle after the accepting edge, with `div_zero_o`=1, quotient 0, remainder 0 and path code 3.
- R2: A nonzero divisor with exactly one bit set, including 1, finishes in the cycle after the accepting edge. Its quotient is the dividend shifted right by the bit index and its remainder is the dividend's bits below that index. The path code is 0.
- R3: A divisor in 3..2^SMALL_BITS-1 that is not a power of two uses the table route with path code 1. `done_o` rises MUL_LAT+4 cycles after the accepting edge (8 with the default MUL_LAT=4).
- R4: Any other nonzero divisor uses the bit-serial route with path code 2. `done_o` rises W+2 cycles after the accepting edge (34 with the default W=32).
- R5: For every nonzero divisor, quotient×divisor+remainder equals the dividend and the remainder is below the divisor, on every route.
- R6: `done_o` is high for exactly one cycle per accepted request, and `div_zero_o` is 0 on every result whose divisor was nonzero.
- R7: A `start_i` pulse while `ready_o` is low is ignored. The running request finishes with its own result and no extra `done_o` follows.
- R8: A synchronous reset clears `done_o`, `div_zero_o`, quotient and remainder to 0 and sets `ready_o` high.
- R9: `ready_o` is low from the accepting edge of a table or bit-serial request until the cycle in which its `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, sampled while ready_o is high |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| ready_o | output | 1 | Idle and able to accept a request |
| done_o | output | 1 | One-cycle result pulse |
| div_zero_o | output | 1 | Divisor was zero (valid with done_o) |
| quotient_o | output | W | Floor quotient |
| remainder_o | output | W | Remainder |
| path_o | output | 2 | Route code: 0 shift, 1 table, 2 bit-serial, 3 zero |

## Verification
The bench builds the divider with W=32, SMALL_BITS=8 and MUL_LAT=4. With SMALL_BITS=8 the whole table range is small enough to sweep every divisor from 1 to 255. Each divisor is tried with dividends 0, 1, all-ones and a random value, which tests both rounding directions of the estimate and the all-ones case where the estimate is most often off by one. With W=32, bit-serial requests take 34 cycles, so random wide divisors and a start pulse during a busy request stay cheap to run. MUL_LAT=4 fixes the table latency at 8, and the bench checks that count exactly.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    PATH_SHIFT = 2'd0,
    PATH_TABLE = 2'd1,
    PATH_ITER  = 2'd2,
    PATH_ZERO  = 2'd3
  } path_e;
endpackage

// File: rtl/recip_rom.sv
// Reciprocal table: entry i holds floor(2^W / i), read with one cycle latency.
module recip_rom #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  output logic [W-1:0]  data_o
);
  localparam int DEPTH = 2 ** AW;
  localparam int XW    = 2 * W;

  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i < 2) mem[i] = '0;
      else       mem[i] = W'((XW'(1) << W) / XW'(i));
    end
  end

  always_ff @(posedge clk_i) begin
    data_o <= mem[addr_i];
  end
endmodule

// File: rtl/pipe_mult.sv
// Pipelined unsigned multiplier; LAT register stages, low DROP bits discarded.
module pipe_mult #(
  parameter int AW   = 32,
  parameter int BW   = 32,
  parameter int LAT  = 4,
  parameter int DROP = 31
) (
  input  logic                    clk_i,
  input  logic [AW-1:0]           a_i,
  input  logic [BW-1:0]           b_i,
  output logic [AW+BW-DROP-1:0]   p_o
);
  localparam int FW = AW + BW;
  localparam int PW = FW - DROP;

  logic [PW-1:0] stg_q [LAT];

  always_ff @(posedge clk_i) begin
    stg_q[0] <= PW'(({{BW{1'b0}}, a_i} * {{AW{1'b0}}, b_i}) >> DROP);
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk_i) begin
      stg_q[s] <= stg_q[s-1];
    end
  end

  assign p_o = stg_q[LAT-1];
endmodule

// File: rtl/radix2_core.sv
// Restoring divider, one quotient bit per cycle, W cycles after load.
module radix2_core #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         fin_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  part_q, quo_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          act_q, fin_q;
  logic [W:0]    trial;
  logic          fits;

  assign trial = {part_q, quo_q[W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      part_q <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        part_q <= '0;
        quo_q  <= dividend_i;
        den_q  <= divisor_i;
        cnt_q  <= '0;
        act_q  <= 1'b1;
      end else if (act_q) begin
        quo_q  <= {quo_q[W-2:0], fits};
        part_q <= fits ? W'(trial - {1'b0, den_q}) : trial[W-1:0];
        cnt_q  <= cnt_q + CW'(1);
        if (cnt_q == CW'(W - 1)) begin
          act_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;
  assign rem_o  = part_q;
  assign fin_o  = fin_q;
endmodule

// File: rtl/recip_divider.sv
module recip_divider
  import div_pkg::*;
#(
  parameter int W          = 32,
  parameter int SMALL_BITS = 8,
  parameter int MUL_LAT    = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         ready_o,
  output logic         done_o,
  output logic         div_zero_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic [1:0]   path_o
);
  localparam int LOGW = $clog2(W);
  localparam int CW   = $clog2(MUL_LAT + 1);
  localparam int QDW  = W + SMALL_BITS;
  localparam int RW   = QDW + 1;

  typedef enum logic [2:0] {S_IDLE, S_MUL, S_RND, S_REM, S_FIX, S_ITER} st_e;

  st_e            st_q;
  logic [W-1:0]   x_q, d_q, quo_q, rem_q, qe_q;
  logic [CW-1:0]  cnt_q;
  logic [RW-1:0]  rs_q;
  logic           done_q, dz_q;
  path_e          path_q;

  // classification of the incoming divisor
  logic           is_zero, is_pow2, is_small, accept;
  logic [LOGW-1:0] sh_amt;
  logic [W-1:0]   sh_quo, sh_rem;

  function automatic logic [LOGW-1:0] msb_pos(input logic [W-1:0] v);
    msb_pos = '0;
    for (int i = 0; i < W; i++) if (v[i]) msb_pos = LOGW'(i);
  endfunction

  assign is_zero  = (divisor_i == '0);
  assign is_pow2  = !is_zero && ((divisor_i & (divisor_i - W'(1))) == '0);
  assign is_small = (divisor_i >> SMALL_BITS) == '0;
  assign sh_amt   = msb_pos(divisor_i);
  assign sh_quo   = dividend_i >> sh_amt;
  assign sh_rem   = dividend_i & (divisor_i - W'(1));
  assign accept   = start_i && (st_q == S_IDLE);

  // table route datapath
  logic [W-1:0]  rom_q;
  logic [W:0]    prod_hi;
  logic [QDW-1:0] qd;

  recip_rom #(.W(W), .AW(SMALL_BITS)) i_rom (
    .clk_i  (clk_i),
    .addr_i (divisor_i[SMALL_BITS-1:0]),
    .data_o (rom_q)
  );

  pipe_mult #(.AW(W), .BW(W), .LAT(MUL_LAT), .DROP(W - 1)) i_mult (
    .clk_i (clk_i),
    .a_i   (x_q),
    .b_i   (rom_q),
    .p_o   (prod_hi)
  );

  assign qd = QDW'(qe_q) * QDW'(d_q[SMALL_BITS-1:0]);

  // bit-serial route
  logic [W-1:0] core_q, core_r;
  logic         core_fin;

  radix2_core #(.W(W)) i_core (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (accept && !is_zero && !is_pow2 && !is_small),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quot_o     (core_q),
    .rem_o      (core_r),
    .fin_o      (core_fin)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q   <= S_IDLE;
      x_q    <= '0;
      d_q    <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      qe_q   <= '0;
      rs_q   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      path_q <= PATH_SHIFT;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          x_q   <= dividend_i;
          d_q   <= divisor_i;
          cnt_q <= '0;
          if (is_zero) begin
            done_q <= 1'b1;
            dz_q   <= 1'b1;
            quo_q  <= '0;
            rem_q  <= '0;
            path_q <= PATH_ZERO;
          end else if (is_pow2) begin
            done_q <= 1'b1;
            dz_q   <= 1'b0;
            quo_q  <= sh_quo;
            rem_q  <= sh_rem;
            path_q <= PATH_SHIFT;
          end else if (is_small) begin
            st_q <= S_MUL;
          end else begin
            st_q <= S_ITER;
          end
        end
        S_MUL: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(MUL_LAT - 1)) st_q <= S_RND;
        end
        S_RND: begin
          qe_q <= prod_hi[W:1] + W'(prod_hi[0]);
          st_q <= S_REM;
        end
        S_REM: begin
          rs_q <= RW'(x_q) - RW'(qd);
          st_q <= S_FIX;
        end
        S_FIX: begin
          if (rs_q[RW-1]) begin
            quo_q <= qe_q - W'(1);
            rem_q <= W'(rs_q + RW'(d_q));
          end else if (rs_q >= RW'(d_q)) begin
            quo_q <= qe_q + W'(1);
            rem_q <= W'(rs_q - RW'(d_q));
          end else begin
            quo_q <= qe_q;
            rem_q <= W'(rs_q);
          end
          done_q <= 1'b1;
          dz_q   <= 1'b0;
          path_q <= PATH_TABLE;
          st_q   <= S_IDLE;
        end
        S_ITER: if (core_fin) begin
          quo_q  <= core_q;
          rem_q  <= core_r;
          done_q <= 1'b1;
          dz_q   <= 1'b0;
          path_q <= PATH_ITER;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ready_o     = (st_q == S_IDLE);
  assign done_o      = done_q;
  assign div_zero_o  = dz_q;
  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
  assign path_o      = path_q;
endmodule

// File: rtl/recip_divider_chk.sv
module recip_divider_chk #(
  parameter int W          = 32,
  parameter int SMALL_BITS = 8
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic         start_i,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         ready_o,
  input logic         done_o,
  input logic         div_zero_o,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o,
  input logic [1:0]   path_o
);
  logic [W-1:0] xcap, dcap;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      xcap <= '0;
      dcap <= '0;
    end else if (start_i && ready_o) begin
      xcap <= dividend_i;
      dcap <= divisor_i;
    end
  end

  // R1
  zero_result_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o && div_zero_o |-> quotient_o == '0 && remainder_o == '0 && path_o == 2'd3 && dcap == '0);

  // R5
  exact_result_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o && !div_zero_o |-> remainder_o < dcap &&
      ({{W{1'b0}}, quotient_o} * {{W{1'b0}}, dcap} + {{W{1'b0}}, remainder_o}) == {{W{1'b0}}, xcap});

  // R3
  table_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o && path_o == 2'd1 |-> dcap > W'(2) && (dcap >> SMALL_BITS) == '0);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o && dcap != '0 |-> !div_zero_o);

  // R9
  ready_at_done_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> ready_o);

  // R8
  reset_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> !done_o && !div_zero_o && quotient_o == '0 && remainder_o == '0 && ready_o);
endmodule

bind recip_divider recip_divider_chk #(.W(W), .SMALL_BITS(SMALL_BITS)) i_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .start_i     (start_i),
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .div_zero_o  (div_zero_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .path_o      (path_o)
);

// File: tb/test_recip_divider.sv
module test_recip_divider;
  localparam int W = 32;
  localparam int NV = 10;

  localparam logic [W-1:0] VX [NV] = '{32'd100, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd1000, 32'd12345,
                                       32'd5, 32'hFFFFFFFF, 32'h80000000, 32'd7, 32'd1000000};
  localparam logic [W-1:0] VD [NV] = '{32'd7, 32'hFFFFFFFF, 32'd256, 32'd1000, 32'd1,
                                       32'd0, 32'd255, 32'h80000000, 32'd300, 32'd3};
  localparam logic [W-1:0] VQ [NV] = '{32'd14, 32'd1, 32'h00FFFFFF, 32'd1, 32'd12345,
                                       32'd0, 32'h01010101, 32'd1, 32'd0, 32'd333333};
  localparam logic [W-1:0] VR [NV] = '{32'd2, 32'd0, 32'hFF, 32'd0, 32'd0,
                                       32'd0, 32'd0, 32'd0, 32'd7, 32'd1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic ready, done, dz;
  logic [W-1:0] quo, rem;
  logic [1:0] path;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  recip_divider #(.W(W), .SMALL_BITS(8), .MUL_LAT(4)) i_recip_divider (
    .clk_i(clk), .rst_i(rst), .start_i(start), .dividend_i(dvd), .divisor_i(dvs),
    .ready_o(ready), .done_o(done), .div_zero_o(dz), .quotient_o(quo),
    .remainder_o(rem), .path_o(path)
  );

  function automatic int exp_path(logic [W-1:0] d);
    if (d == '0) return 3;
    if ((d & (d - 32'd1)) == '0) return 0;
    if (d < 32'd256) return 1;
    return 2;
  endfunction

  function automatic int exp_lat(int p);
    if (p == 1) return 8;
    if (p == 2) return 34;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string line);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", line);
    end
  endtask

  task automatic run(input logic [W-1:0] x, input logic [W-1:0] d,
                     input logic [W-1:0] eq, input logic [W-1:0] er);
    string ptag [4] = '{"R2", "R3", "R4", "R1"};
    int p = exp_path(d);
    int lat;
    @(negedge clk);
    start = 1'b1; dvd = x; dvs = d;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      if (lat == 2 && (p == 1 || p == 2))
        chk(!ready, $sformatf("R9 ready during busy: actual=%0b expected=0 (d=%0h)", ready, d));
      @(negedge clk);
      lat++;
    end
    chk(done && quo == eq && rem == er && dz == (d == '0),
        $sformatf("R5 %0h/%0h: actual q=%0h r=%0h dz=%0b done=%0b expected q=%0h r=%0h dz=%0b",
                  x, d, quo, rem, dz, done, eq, er, d == '0));
    chk(int'(path) == p && lat == exp_lat(p),
        $sformatf("%s %0h/%0h path/latency: actual %0d/%0d expected %0d/%0d",
                  ptag[p], x, d, path, lat, p, exp_lat(p)));
    @(negedge clk);
    chk(!done, $sformatf("R6 done pulse length: actual done=%0b expected 0", done));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(!done && !dz && quo == '0 && rem == '0 && ready,
        $sformatf("R8 reset: actual done=%0b dz=%0b q=%0h r=%0h ready=%0b expected 0/0/0/0/1",
                  done, dz, quo, rem, ready));

    // vector table
    for (int i = 0; i < NV; i++) run(VX[i], VD[i], VQ[i], VR[i]);

    // sweep table and shift divisors (R2, R3, R5)
    for (int d = 1; d < 256; d++) begin
      logic [W-1:0] xs [4];
      xs[0] = '0; xs[1] = 32'd1; xs[2] = 32'hFFFFFFFF; xs[3] = $urandom;
      for (int k = 0; k < 4; k++) run(xs[k], W'(d), xs[k] / W'(d), xs[k] % W'(d));
    end

    // wide divisors, bit-serial route (R4, R5)
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] x, d;
      x = $urandom;
      d = ($urandom >> (k % 24)) | 32'h100;
      run(x, d, x / d, x % d);
    end

    // R7: start pulse while busy is ignored
    @(negedge clk);
    start = 1'b1; dvd = 32'd100; dvs = 32'd7;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; dvd = 32'd55; dvs = 32'd0;
    @(negedge clk);
    start = 1'b0;
    begin
      int lat = 3;
      while (!done && lat < 100) begin
        @(negedge clk);
        lat++;
      end
      chk(done && quo == 32'd14 && rem == 32'd2 && !dz && path == 2'd1 && lat == 8,
          $sformatf("R7 busy start: actual q=%0d r=%0d dz=%0b path=%0d lat=%0d expected 14/2/0/1/8",
                    quo, rem, dz, path, lat));
    end
    begin
      int extra = 0;
      repeat (12) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, $sformatf("R7 extra done pulses: actual=%0d expected=0", extra));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule